// File: doc/BRIEF.md
# CAN Transmit Buffer Scheduler

This block sits between software and the bit-level transmitter of a CAN controller. It owns the request state of nine transmit message buffers. Whenever the transmitter is free to begin a new frame, the block compares the software-assigned priorities of every pending buffer. It then issues a start strobe together with the index of the winning buffer. The index stays latched until the transmitter reports how that frame ended.

Software cancels work in two ways. It can issue a per-buffer cancel pulse, or a cancel-everything pulse that covers every buffer pending at that moment. A buffer that is not on the bus is dropped at once. A buffer whose frame is already on the bus keeps going: if the frame succeeds, it completes normally. If the frame fails through lost arbitration or a bus error, the buffer is dropped rather than retried. Dropped buffers raise a sticky abort-done flag that only a fresh request or reset lowers.

Buffers 8, 7 and 6 play the role of dedicated transmit buffers, and buffers 5 down to 0 play the role of shared buffers.

Top module: `can_tx_sched`

## Requirements
- R1: Each buffer has a 2-bit priority in `prio_flat[2*i+1:2*i]`, where 3 is the highest level and 0 the lowest. At every selection point, the pending buffer with the highest priority value is chosen.
- R2: When pending buffers share the top priority, the one with the larger index wins. This gives the tie-break order 8, 7, 6, then 5, 4, 3, 2, 1, 0.
- R3: Only buffers whose request is set take part in selection. A selection happens only when the block is idle, `tx_ready` is high and at least one buffer is eligible. Otherwise no `tx_start` is issued.
- R4: `tx_start` is a one-cycle pulse in the cycle after the selection point. `tx_sel` is loaded with it. `tx_busy` and `tx_sel` then hold steady until a completion, arbitration-loss or error event arrives.
- R5: On `ev_tx_ok` while busy, the request of the selected buffer clears at the next edge. A one-cycle pulse appears on that buffer's bit of `tx_done` at the same edge.
- R6: On `ev_arb_lost` or `ev_bus_err` with no abort outstanding, the request stays set. The buffer competes again, so it can start in the cycle after the next selection point.
- R7: A `req_abort` pulse on a pending buffer that is not in flight clears its request and sets its `abort_done` bit at the next edge.
- R8: An abort of the buffer in flight is deferred. If the frame then succeeds, the request clears, `tx_done` pulses and `abort_done` stays low.
- R9: If the frame of an aborted in-flight buffer ends in lost arbitration or an error, the request clears, `abort_done` rises at the same edge, and the buffer is not restarted.
- R10: `abort_all_set` treats every pending buffer as aborted under R7 to R9 and raises `abort_all_pend` at the next edge. `abort_all_pend` falls one edge after the last deferred abort has resolved.
- R11: `abort_done` bits and `abort_all_pend` have no software clear. An `abort_done` bit falls only when `req_set` re-arms that buffer (request set and flag cleared at the same edge) or on reset. A `req_set` on a buffer that is already pending has no effect.
- R12: While `rst_n` is low at a clock edge, every request, flag, strobe and `tx_sel` is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set | input | 9 | Per-buffer pulse: arm a transmit request |
| req_abort | input | 9 | Per-buffer pulse: cancel a pending request |
| prio_flat | input | 18 | Two priority bits per buffer, buffer i at bits 2i+1:2i |
| abort_all_set | input | 1 | Pulse: cancel every pending request |
| tx_ready | input | 1 | Transmitter can accept a new frame |
| ev_tx_ok | input | 1 | Transmitter: frame completed successfully |
| ev_arb_lost | input | 1 | Transmitter: arbitration lost |
| ev_bus_err | input | 1 | Transmitter: frame ended in error |
| tx_start | output | 1 | One-cycle start strobe |
| tx_sel | output | 4 | Index of the buffer being sent |
| tx_busy | output | 1 | A frame is in flight |
| req_pend | output | 9 | Current request bits |
| abort_all_pend | output | 1 | Cancel-everything still being resolved |
| abort_done | output | 9 | Sticky per-buffer aborted flags |
| tx_done | output | 9 | One-cycle per-buffer success pulse |

## Verification
Every result of this block is registered once. Request, flag and `tx_done` changes therefore appear one edge after the pulse or event that causes them. The start strobe appears one edge after the cycle in which `tx_ready` and a pending buffer coincide. The one exception is the fall of `abort_all_pend`, which comes one further edge after the last deferred abort resolves. The bench drives each stimulus on a falling edge and samples on the next falling edge for single-edge results. It waits exactly one more falling edge for a restart after a completion and for the fall of the cancel-everything flag. A sweep over many priority and request patterns drains each pattern buffer by buffer. It checks every start index against an arithmetic model of the priority and tie-break rules.

// File: rtl/can_txs_pkg.sv
// can_txs_pkg: types shared by the transmit buffer scheduler.
// Assumes a 2-bit priority field per buffer; larger value means more urgent.
package can_txs_pkg;

    localparam int unsigned PRIO_W = 2;

    typedef logic [PRIO_W-1:0] prio_t;

    // Sequencer state: waiting for a selection point, or a frame in flight.
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_e;

    // Outcome of the frame in flight, as seen by one buffer.
    typedef struct packed {
        logic ok;    // frame went out without error
        logic fail;  // arbitration lost or bus error
    } frame_res_t;

endpackage

// File: rtl/txs_pick_arb.sv
// txs_pick_arb: combinational selector over the eligible buffers.
// Picks the highest priority value; on equal priority the larger index wins.
// Assumes at most one pick is consumed per selection point by the sequencer.
module txs_pick_arb
    import can_txs_pkg::*;
#(
    parameter int unsigned N     = 9,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]        elig,
    input  logic [N*PRIO_W-1:0] prio_flat,
    output logic                found,
    output logic [IDX_W-1:0]    pick
);

    prio_t pr [N];
    prio_t best_pr;

    // Split the flat priority bus into one field per buffer.
    for (genvar g = 0; g < N; g++) begin : g_split
        assign pr[g] = prio_flat[g*PRIO_W +: PRIO_W];
    end

    // Ascending scan; ">=" lets a later (larger) index take ties.
    always_comb begin
        found   = 1'b0;
        pick    = '0;
        best_pr = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!found || (pr[i] >= best_pr))) begin
                found   = 1'b1;
                best_pr = pr[i];
                pick    = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/txs_buf_slot.sv
// txs_buf_slot: request and abort state for one transmit buffer.
// Assumes in_flight is high only while this buffer's frame is on the bus and
// that res carries at most one outcome per frame.
module txs_buf_slot
    import can_txs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_set,      // arm a request
    input  logic       sw_abort,    // cancel this buffer
    input  logic       abort_all,   // cancel every pending buffer
    input  logic       in_flight,   // this buffer is being sent
    input  frame_res_t res,         // outcome of the frame in flight
    output logic       req,
    output logic       abrt_pend,   // abort deferred until the frame ends
    output logic       abort_done,
    output logic       tx_done,
    output logic       eligible
);

    logic abort_req;
    logic fin_ok;
    logic fin_fail;

    // An abort only applies to a buffer that is currently pending.
    assign abort_req = (sw_abort | abort_all) & req;
    assign fin_ok    = in_flight & res.ok;
    assign fin_fail  = in_flight & res.fail;

    // Pending and not being cancelled in this cycle.
    assign eligible  = req & ~abort_req;

    // Request/abort bookkeeping for this buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req        <= 1'b0;
            abrt_pend  <= 1'b0;
            abort_done <= 1'b0;
            tx_done    <= 1'b0;
        end else begin
            tx_done <= 1'b0;
            if (fin_ok) begin
                req       <= 1'b0;
                abrt_pend <= 1'b0;
                tx_done   <= 1'b1;
            end else if (fin_fail) begin
                if (abrt_pend || abort_req) begin
                    req        <= 1'b0;
                    abrt_pend  <= 1'b0;
                    abort_done <= 1'b1;
                end
            end else if (abort_req) begin
                if (in_flight) begin
                    abrt_pend <= 1'b1;
                end else begin
                    req        <= 1'b0;
                    abort_done <= 1'b1;
                end
            end else if (sw_set && !req) begin
                req        <= 1'b1;
                abort_done <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/txs_seq_ctrl.sv
// txs_seq_ctrl: frame sequencer and cancel-everything flag.
// Issues the start strobe at a selection point, latches the chosen index and
// holds it until the transmitter reports an outcome.
// Assumes outcome events arrive only while a frame is in flight.
module txs_seq_ctrl
    import can_txs_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_ready,
    input  logic             any_elig,
    input  logic [IDX_W-1:0] pick,
    input  logic             frame_end,
    input  logic             abort_all_set,
    input  logic             abrt_any,
    output logic             tx_start,
    output logic [IDX_W-1:0] sel,
    output logic             busy,
    output logic             abort_all_pend
);

    seq_state_e state;

    assign busy = (state == SEQ_BUSY);

    // Idle/busy sequencing with latched selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            sel      <= '0;
            tx_start <= 1'b0;
        end else begin
            tx_start <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (tx_ready && any_elig) begin
                        state    <= SEQ_BUSY;
                        sel      <= pick;
                        tx_start <= 1'b1;
                    end
                end
                SEQ_BUSY: begin
                    if (frame_end) begin
                        state <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Cancel-everything flag: set by request, drops once no abort is deferred.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_all_pend <= 1'b0;
        end else if (abort_all_set) begin
            abort_all_pend <= 1'b1;
        end else if (!abrt_any) begin
            abort_all_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/can_tx_sched.sv
// can_tx_sched: transmit buffer scheduler for a CAN controller.
// Holds per-buffer requests, selects the next buffer by priority with a fixed
// index tie-break, and resolves abort requests at safe points only.
// Assumes the transmitter raises exactly one of ev_tx_ok, ev_arb_lost or
// ev_bus_err once per started frame.
module can_tx_sched
    import can_txs_pkg::*;
#(
    parameter int unsigned N     = 9,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        req_set,
    input  logic [N-1:0]        req_abort,
    input  logic [N*PRIO_W-1:0] prio_flat,
    input  logic                abort_all_set,
    input  logic                tx_ready,
    input  logic                ev_tx_ok,
    input  logic                ev_arb_lost,
    input  logic                ev_bus_err,
    output logic                tx_start,
    output logic [IDX_W-1:0]    tx_sel,
    output logic                tx_busy,
    output logic [N-1:0]        req_pend,
    output logic                abort_all_pend,
    output logic [N-1:0]        abort_done,
    output logic [N-1:0]        tx_done
);

    logic [N-1:0]     elig;
    logic [N-1:0]     abrt_pend;
    logic [N-1:0]     in_flight;
    logic             any_elig;
    logic [IDX_W-1:0] pick;
    logic             frame_end;
    frame_res_t       res;

    // Outcomes count only while a frame is in flight; success takes precedence.
    assign res.ok    = tx_busy & ev_tx_ok;
    assign res.fail  = tx_busy & ~ev_tx_ok & (ev_arb_lost | ev_bus_err);
    assign frame_end = res.ok | res.fail;

    // One state slot per buffer.
    for (genvar g = 0; g < N; g++) begin : g_slot
        assign in_flight[g] = tx_busy & (tx_sel == IDX_W'(g));

        txs_buf_slot i_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .sw_set     (req_set[g]),
            .sw_abort   (req_abort[g]),
            .abort_all  (abort_all_set),
            .in_flight  (in_flight[g]),
            .res        (res),
            .req        (req_pend[g]),
            .abrt_pend  (abrt_pend[g]),
            .abort_done (abort_done[g]),
            .tx_done    (tx_done[g]),
            .eligible   (elig[g])
        );
    end

    txs_pick_arb #(
        .N     (N),
        .IDX_W (IDX_W)
    ) i_arb (
        .elig      (elig),
        .prio_flat (prio_flat),
        .found     (any_elig),
        .pick      (pick)
    );

    txs_seq_ctrl #(
        .IDX_W (IDX_W)
    ) i_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_ready       (tx_ready),
        .any_elig       (any_elig),
        .pick           (pick),
        .frame_end      (frame_end),
        .abort_all_set  (abort_all_set),
        .abrt_any       (|abrt_pend),
        .tx_start       (tx_start),
        .sel            (tx_sel),
        .busy           (tx_busy),
        .abort_all_pend (abort_all_pend)
    );

endmodule

// File: rtl/can_tx_sched_chk.sv
// can_tx_sched_chk: property checker attached to can_tx_sched by bind.
// Observes the top-level ports only.
module can_tx_sched_chk #(
    parameter int unsigned N     = 9,
    parameter int unsigned IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     req_set,
    input logic             ev_tx_ok,
    input logic             tx_start,
    input logic [IDX_W-1:0] tx_sel,
    input logic             tx_busy,
    input logic [N-1:0]     req_pend,
    input logic [N-1:0]     abort_done,
    input logic [N-1:0]     tx_done
);

    AST_START_ON_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> req_pend[tx_sel]); // R3

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start); // R4

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && $past(tx_busy)) |-> $stable(tx_sel)); // R4

    AST_TXDONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_done)); // R5

    AST_TXDONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_done) |-> $past(ev_tx_ok && tx_busy)); // R5

    AST_ABORTED_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_done & req_pend) == '0); // R7

    AST_ABORT_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(abort_done) & ~$past(req_set) & ~abort_done) == '0); // R11

endmodule

bind can_tx_sched can_tx_sched_chk #(
    .N     (N),
    .IDX_W (IDX_W)
) i_can_tx_sched_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_set    (req_set),
    .ev_tx_ok   (ev_tx_ok),
    .tx_start   (tx_start),
    .tx_sel     (tx_sel),
    .tx_busy    (tx_busy),
    .req_pend   (req_pend),
    .abort_done (abort_done),
    .tx_done    (tx_done)
);

// File: tb/test_can_tx_sched.sv
module test_can_tx_sched;

    localparam int NB = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] req_set = '0;
    logic [NB-1:0] req_abort = '0;
    logic [2*NB-1:0] prio_flat = '0;
    logic          abort_all_set = 1'b0;
    logic          tx_ready = 1'b0;
    logic          ev_tx_ok = 1'b0;
    logic          ev_arb_lost = 1'b0;
    logic          ev_bus_err = 1'b0;
    logic          tx_start;
    logic [3:0]    tx_sel;
    logic          tx_busy;
    logic [NB-1:0] req_pend;
    logic          abort_all_pend;
    logic [NB-1:0] abort_done;
    logic [NB-1:0] tx_done;

    int checks = 0;
    int failures = 0;
    int pr_cur [NB];

    always #4 clk = ~clk;

    can_tx_sched i_can_tx_sched (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_abort(req_abort),
        .prio_flat(prio_flat), .abort_all_set(abort_all_set), .tx_ready(tx_ready),
        .ev_tx_ok(ev_tx_ok), .ev_arb_lost(ev_arb_lost), .ev_bus_err(ev_bus_err),
        .tx_start(tx_start), .tx_sel(tx_sel), .tx_busy(tx_busy), .req_pend(req_pend),
        .abort_all_pend(abort_all_pend), .abort_done(abort_done), .tx_done(tx_done)
    );

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic load_prio();
        for (int i = 0; i < NB; i++) prio_flat[2*i +: 2] = 2'(pr_cur[i]);
    endtask

    function automatic int model_pick(input logic [NB-1:0] m);
        int best = -1;
        int bp = -1;
        for (int i = 0; i < NB; i++)
            if (m[i] && pr_cur[i] >= bp) begin best = i; bp = pr_cur[i]; end
        return best;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_set = '0; req_abort = '0; abort_all_set = 1'b0;
        tx_ready = 1'b0; ev_tx_ok = 1'b0; ev_arb_lost = 1'b0; ev_bus_err = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Arm a set of requests with tx_ready low; returns at a falling edge.
    task automatic arm(input logic [NB-1:0] m);
        req_set = m;
        @(negedge clk);
        req_set = '0;
    endtask

    // Drain one pattern completely, checking the start order against the model.
    task automatic run_pattern(input int p);
        logic [NB-1:0] rem;
        int exp;
        for (int i = 0; i < NB; i++)
            pr_cur[i] = (p % 5 == 4) ? ((p / 5) % 4) : ((i * (p + 1) + p) % 4);
        rem = NB'((p * 53 + 17) % 511) | NB'(1 << (p % NB));
        if (p == 0) rem = '1;
        @(negedge clk);
        load_prio();
        arm(rem);
        chk("R3", "requests armed", req_pend, rem);
        tx_ready = 1'b1;
        @(negedge clk);
        while (rem != '0) begin
            exp = model_pick(rem);
            chk("R1 R2", "start strobe", tx_start, 1);
            chk("R1 R2", "selected buffer", tx_sel, exp);
            ev_tx_ok = 1'b1;
            @(negedge clk);
            ev_tx_ok = 1'b0;
            rem[exp] = 1'b0;
            chk("R5", "tx_done pulse", tx_done, 1 << exp);
            chk("R5", "request cleared", req_pend, rem);
            if (rem != '0) @(negedge clk);
        end
        @(negedge clk);
        chk("R3", "no start when empty", tx_start, 0);
        chk("R5", "tx_done back low", tx_done, 0);
        tx_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL WATCHDOG: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R12: state after reset
        chk("R12", "req_pend", req_pend, 0);
        chk("R12", "abort_done", abort_done, 0);
        chk("R12", "start/busy/sel", {tx_start, tx_busy, tx_sel}, 0);
        chk("R12", "abort_all_pend", abort_all_pend, 0);

        // R3: nothing pending -> no strobe even with tx_ready high
        tx_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3", "no start with no requests", tx_start, 0);
        tx_ready = 1'b0;
        arm(9'h008);
        repeat (3) @(negedge clk);
        chk("R3", "no start while tx_ready low", {tx_start, tx_busy}, 0);
        do_reset();

        for (int p = 0; p < 40; p++) run_pattern(p);

        // R6 and R4: retry after failure, selection held while busy
        do_reset();
        for (int i = 0; i < NB; i++) pr_cur[i] = 1;
        load_prio();
        arm(9'h010);
        tx_ready = 1'b1;
        @(negedge clk);
        chk("R4", "start on buffer 4", {tx_start, tx_sel}, {1'b1, 4'd4});
        arm(9'h100);
        prio_flat[2*8 +: 2] = 2'd3;
        repeat (2) @(negedge clk);
        chk("R4", "selection held while busy", {tx_busy, tx_sel, tx_start}, {1'b1, 4'd4, 1'b0});
        prio_flat[2*8 +: 2] = 2'd0;
        ev_arb_lost = 1'b1;
        @(negedge clk);
        ev_arb_lost = 1'b0;
        chk("R6", "request kept after arbitration loss", req_pend, 9'h110);
        chk("R6", "no abort flag", abort_done, 0);
        @(negedge clk);
        chk("R6", "buffer 4 restarts", {tx_start, tx_sel}, {1'b1, 4'd4});
        ev_bus_err = 1'b1;
        @(negedge clk);
        ev_bus_err = 1'b0;
        chk("R6", "request kept after error", req_pend, 9'h110);
        @(negedge clk);
        chk("R6", "restart after error", {tx_start, tx_sel}, {1'b1, 4'd4});
        tx_ready = 1'b0;
        ev_tx_ok = 1'b1;
        @(negedge clk);
        ev_tx_ok = 1'b0;

        // R7 and R11: abort of an idle buffer, stickiness, re-arm
        do_reset();
        arm(9'h004);
        arm(9'h004);
        chk("R11", "set on pending buffer has no effect", {req_pend, abort_done}, {9'h004, 9'h000});
        req_abort = 9'h004;
        @(negedge clk);
        req_abort = '0;
        chk("R7", "idle abort clears request", req_pend, 0);
        chk("R7", "idle abort sets flag", abort_done, 9'h004);
        repeat (3) @(negedge clk);
        chk("R11", "flag stays set", abort_done, 9'h004);
        arm(9'h004);
        chk("R11", "re-arm clears flag", {req_pend, abort_done}, {9'h004, 9'h000});

        // R8: in-flight abort, frame succeeds
        do_reset();
        arm(9'h020);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R8", "buffer 5 started", {tx_start, tx_sel}, {1'b1, 4'd5});
        req_abort = 9'h020;
        @(negedge clk);
        req_abort = '0;
        chk("R8", "abort deferred", {req_pend, abort_done}, {9'h020, 9'h000});
        ev_tx_ok = 1'b1;
        @(negedge clk);
        ev_tx_ok = 1'b0;
        chk("R8", "success wins over deferred abort", {req_pend, abort_done, tx_done}, {9'h000, 9'h000, 9'h020});

        // R9: in-flight abort, arbitration lost
        do_reset();
        arm(9'h002);
        tx_ready = 1'b1;
        @(negedge clk);
        chk("R9", "buffer 1 started", {tx_start, tx_sel}, {1'b1, 4'd1});
        req_abort = 9'h002;
        @(negedge clk);
        req_abort = '0;
        ev_arb_lost = 1'b1;
        @(negedge clk);
        ev_arb_lost = 1'b0;
        chk("R9", "aborted after loss", {req_pend, abort_done}, {9'h000, 9'h002});
        repeat (2) @(negedge clk);
        chk("R9", "no retry", {tx_start, tx_busy}, 0);
        tx_ready = 1'b0;

        // R10: cancel everything with one buffer in flight
        do_reset();
        for (int i = 0; i < NB; i++) pr_cur[i] = i % 4;
        load_prio();
        arm(9'h089);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R10", "in-flight buffer", tx_sel, model_pick(9'h089));
        abort_all_set = 1'b1;
        @(negedge clk);
        abort_all_set = 1'b0;
        chk("R10", "flag raised", abort_all_pend, 1);
        chk("R10", "idle buffers aborted", abort_done, 9'h089 & ~(9'h1 << model_pick(9'h089)));
        chk("R10", "in-flight kept", req_pend, 9'h1 << model_pick(9'h089));
        ev_bus_err = 1'b1;
        @(negedge clk);
        ev_bus_err = 1'b0;
        chk("R10", "all aborted", {req_pend, abort_done}, {9'h000, 9'h089});
        chk("R11", "flag still set", abort_all_pend, 1);
        @(negedge clk);
        chk("R10", "flag self-clears", abort_all_pend, 0);
        abort_all_set = 1'b1;
        @(negedge clk);
        abort_all_set = 1'b0;
        chk("R10", "flag with nothing pending", abort_all_pend, 1);
        @(negedge clk);
        chk("R10", "flag clears next edge", abort_all_pend, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule